// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block applies the architectural state changes a small processor core makes when it takes an exception and when a handler returns. The core's prioritisation logic presents one request at a time with a kind code. In one clock edge the sequencer then supplies the vector address to fetch from, a link-register write holding the resume address, a saved-status write, and the new current status. The resume address is the interrupted PC plus an offset. That offset depends on both the exception kind and the instruction-set state that was running. Because of this, a handler returns the same way whichever state it interrupted.

The block keeps one saved-status slot for each exception mode. A return strobe reads the slot that belongs to the current mode and drives it out as the new current status. This restores the mode, the state bits and the mask bits together, and the PC is loaded with the supplied return address. Three routing bits can send FIQ, IRQ and external aborts into monitor mode instead of their usual modes. The pipeline, the register file and instruction decode are outside the block. The sequencer only emits write strobes and data for them.

Top module: `exc_ctrl_top`

## Requirements
- R1: While `rstN` is low, `pcLoad` and `statusWrEn` are 1, `pcNext` is the vector base (0 by default), and `statusOut` is 0x1D3. That value is supervisor mode with I, F and A set and T, J and the flags clear. `linkWrEn` and `savedWrEn` are 0. The status word layout is: [13:10] flags, [9] J, [8] A, [7] I, [6] F, [5] T, [4:0] mode.
- R2: An accepted request sets `pcLoad` and sets `pcNext` to the base plus a vector offset chosen by `excKind`. The kinds and offsets are: 0 reset 0x00, 1 undefined 0x04, 2 supervisor call 0x08, 3 prefetch abort 0x0C, 4 data abort 0x10, 5 IRQ 0x18, 6 FIQ 0x1C. Kind 7 is never accepted.
- R3: `linkData` is `curPc` plus an offset. When `isaState` is 0 (primary) or 2 (bytecode), the offset is +4 for undefined, supervisor call, prefetch abort, IRQ and FIQ, and +8 for data abort. When `isaState` is 1 (16-bit compressed), the offset is +2 for undefined and supervisor call, +4 for prefetch abort, IRQ and FIQ, and +8 for data abort.
- R4: The target mode codes are undefined 11011, supervisor call 10011, prefetch and data abort 10111, IRQ 10010, FIQ 10001 and reset 10011. When `routeCtl[0]` is set, FIQ goes to monitor mode (10110) instead. `routeCtl[1]` does the same for IRQ. `routeCtl[2]` does the same for aborts that carry `abtExternal`.
- R5: For every request kind except reset, `savedWrEn` and `linkWrEn` each pulse for one cycle. `savedData` equals the `curStatus` value that was sampled with the request, and `savedMode` and `linkMode` both equal the target mode.
- R6: On entry, `statusOut` takes the target mode with T and J cleared and the flags copied from `curStatus`.
- R7: On entry, I is always set. F is set on reset and FIQ and otherwise copied from the current status. A is set on reset, both aborts and IRQ and otherwise copied.
- R8: A return with `retStrobe` high sets `pcNext` to `retAddr`. It also sets `statusOut` to the value last saved for the mode in `curStatus[4:0]` and pulses `pcLoad` and `statusWrEn`. `linkWrEn` and `savedWrEn` stay 0.
- R9: A return while `curStatus[4:0]` names a mode without a saved slot, such as user 10000, has no effect: no strobe rises.
- R10: When `excReq` and `retStrobe` are high in the same cycle, the exception entry is performed and the return is dropped.
- R11: A reset request (kind 0) performs the entry of R2, R6 and R7 but writes neither the link nor the saved status.
- R12: The outputs change on the clock edge that samples the request. Every strobe is 0 in a cycle that follows an edge with no request and no return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset; enters the reset exception |
| excReq | input | 1 | A prioritised exception is requested this cycle |
| excKind | input | 3 | Exception kind code |
| abtExternal | input | 1 | The abort being requested is external |
| curPc | input | 32 | PC of the interrupted instruction |
| curStatus | input | 14 | Current status word |
| isaState | input | 2 | Running instruction-set state |
| routeCtl | input | 3 | Monitor routing bits for FIQ, IRQ and external abort |
| retStrobe | input | 1 | Return request |
| retAddr | input | 32 | Address to resume at on return |
| pcLoad | output | 1 | Load `pcNext` into the PC |
| pcNext | output | 32 | New PC value |
| linkWrEn | output | 1 | Write the link register of `linkMode` |
| linkMode | output | 5 | Mode whose link register is written |
| linkData | output | 32 | Resume address written to the link register |
| savedWrEn | output | 1 | Saved-status write strobe |
| savedMode | output | 5 | Mode whose saved status is written |
| savedData | output | 14 | Status word being saved |
| statusWrEn | output | 1 | Write `statusOut` into the current status |
| statusOut | output | 14 | New current status word |

## Verification
The assertions assume three things about the inputs: at most one prioritised request arrives per cycle, `excKind` is stable and valid while `excReq` is high, and `curStatus` holds the core's real current status. A return is only checked against the saved slot of the mode in `curStatus`. The stimulus changes inputs only at the falling edge and drops `excReq` after one cycle. It presents returns only with a mode whose slot was filled by an earlier entry in the same run. The one exception is the user-mode return, which is there to show that the strobe is dropped.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int STATUS_W  = 14;
  localparam int MODE_W    = 5;
  localparam int NUM_SLOTS = 6;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SUP = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_MON = 5'b10110;

  typedef enum logic [2:0] {
    EXC_RST  = 3'd0,
    EXC_UND  = 3'd1,
    EXC_SCALL = 3'd2,
    EXC_PABT = 3'd3,
    EXC_DABT = 3'd4,
    EXC_IRQ  = 3'd5,
    EXC_FIQ  = 3'd6
  } excKindT;

  typedef enum logic [1:0] {
    ISA_PRIMARY  = 2'd0,
    ISA_COMPACT  = 2'd1,
    ISA_BYTECODE = 2'd2
  } isaT;

  typedef struct packed {
    logic [3:0]        flags;
    logic              jBit;
    logic              aMask;
    logic              iMask;
    logic              fMask;
    logic              tBit;
    logic [MODE_W-1:0] mode;
  } statusT;

  typedef struct packed {
    logic              enter;
    logic              doLink;
    logic              ret;
    logic [MODE_W-1:0] tgtMode;
    logic [4:0]        vecOff;
    logic [3:0]        linkOff;
    logic              setA;
    logic              setF;
    logic [SLOT_W-1:0] entSlot;
    logic [SLOT_W-1:0] retSlot;
  } ctlStrobeT;

  // Maps an exception mode to its saved-status slot; bit SLOT_W flags a hit.
  function automatic logic [SLOT_W:0] slotOf(logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return {1'b1, SLOT_W'(0)};
      MODE_IRQ: return {1'b1, SLOT_W'(1)};
      MODE_SUP: return {1'b1, SLOT_W'(2)};
      MODE_ABT: return {1'b1, SLOT_W'(3)};
      MODE_UND: return {1'b1, SLOT_W'(4)};
      MODE_MON: return {1'b1, SLOT_W'(5)};
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/exc_ctl.sv
module exc_ctl
  import exc_pkg::*;
(
  input  logic              excReq,
  input  logic [2:0]        excKind,
  input  logic              abtExternal,
  input  logic [1:0]        isaState,
  input  logic [2:0]        routeCtl,
  input  logic              retStrobe,
  input  logic [MODE_W-1:0] curMode,
  output ctlStrobeT         strobes
);

  logic              accept;
  logic              compact;
  logic              extRoute;
  logic [SLOT_W:0]   entHit;
  logic [SLOT_W:0]   retHit;

  assign accept   = excReq && (excKind != 3'd7);
  assign compact  = (isaState == ISA_COMPACT);
  assign extRoute = abtExternal && routeCtl[2];
  assign retHit   = slotOf(curMode);

  always_comb begin
    strobes         = '0;
    strobes.enter   = accept;
    strobes.doLink  = accept && (excKind != EXC_RST);
    // R10: a request this cycle takes precedence over a return
    strobes.ret     = !accept && retStrobe && retHit[SLOT_W];
    strobes.retSlot = retHit[SLOT_W-1:0];
    case (excKind)
      EXC_RST: begin
        strobes.tgtMode = MODE_SUP;
        strobes.vecOff  = 5'h00;
        strobes.setA    = 1'b1;
        strobes.setF    = 1'b1;
      end
      EXC_UND: begin
        strobes.tgtMode = MODE_UND;
        strobes.vecOff  = 5'h04;
        strobes.linkOff = compact ? 4'd2 : 4'd4;
      end
      EXC_SCALL: begin
        strobes.tgtMode = MODE_SUP;
        strobes.vecOff  = 5'h08;
        strobes.linkOff = compact ? 4'd2 : 4'd4;
      end
      EXC_PABT: begin
        strobes.tgtMode = extRoute ? MODE_MON : MODE_ABT;
        strobes.vecOff  = 5'h0C;
        strobes.linkOff = 4'd4;
        strobes.setA    = 1'b1;
      end
      EXC_DABT: begin
        strobes.tgtMode = extRoute ? MODE_MON : MODE_ABT;
        strobes.vecOff  = 5'h10;
        strobes.linkOff = 4'd8;
        strobes.setA    = 1'b1;
      end
      EXC_IRQ: begin
        strobes.tgtMode = routeCtl[1] ? MODE_MON : MODE_IRQ;
        strobes.vecOff  = 5'h18;
        strobes.linkOff = 4'd4;
        strobes.setA    = 1'b1;
      end
      EXC_FIQ: begin
        strobes.tgtMode = routeCtl[0] ? MODE_MON : MODE_FIQ;
        strobes.vecOff  = 5'h1C;
        strobes.linkOff = 4'd4;
        strobes.setF    = 1'b1;
      end
      default: begin
        strobes.tgtMode = MODE_SUP;
      end
    endcase
    entHit          = slotOf(strobes.tgtMode);
    strobes.entSlot = entHit[SLOT_W-1:0];
  end

endmodule

// File: rtl/exc_dp.sv
module exc_dp
  import exc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         strobes,
  input  logic              excReq,
  input  logic              retStrobe,
  input  logic [ADDR_W-1:0] curPc,
  input  statusT            curStatus,
  input  logic [ADDR_W-1:0] retAddr,
  output logic              pcLoad,
  output logic [ADDR_W-1:0] pcNext,
  output logic              linkWrEn,
  output logic [MODE_W-1:0] linkMode,
  output logic [ADDR_W-1:0] linkData,
  output logic              savedWrEn,
  output logic [MODE_W-1:0] savedMode,
  output statusT            savedData,
  output logic              statusWrEn,
  output statusT            statusReg
);

  localparam statusT RESET_STATUS = '{flags: 4'h0, jBit: 1'b0, aMask: 1'b1,
                                      iMask: 1'b1, fMask: 1'b1, tBit: 1'b0,
                                      mode: MODE_SUP};

  logic [NUM_SLOTS-1:0][STATUS_W-1:0] bankFlat;
  statusT entryStatus;
  statusT retStatus;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_bank
    statusT slotReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotReg <= '0;
      end else if (strobes.doLink && (strobes.entSlot == SLOT_W'(g))) begin
        slotReg <= curStatus;
      end
    end
    assign bankFlat[g] = slotReg;
  end

  assign retStatus = statusT'(bankFlat[strobes.retSlot]);

  always_comb begin
    entryStatus       = curStatus;
    entryStatus.mode  = strobes.tgtMode;
    entryStatus.tBit  = 1'b0;
    entryStatus.jBit  = 1'b0;
    entryStatus.iMask = 1'b1;
    entryStatus.aMask = curStatus.aMask | strobes.setA;
    entryStatus.fMask = curStatus.fMask | strobes.setF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcLoad     <= 1'b1;
      pcNext     <= VEC_BASE;
      statusWrEn <= 1'b1;
      statusReg  <= RESET_STATUS;
      linkWrEn   <= 1'b0;
      linkMode   <= '0;
      linkData   <= '0;
      savedWrEn  <= 1'b0;
      savedMode  <= '0;
      savedData  <= '0;
    end else begin
      pcLoad     <= 1'b0;
      statusWrEn <= 1'b0;
      linkWrEn   <= 1'b0;
      savedWrEn  <= 1'b0;
      if (strobes.enter) begin
        pcLoad     <= 1'b1;
        pcNext     <= VEC_BASE + ADDR_W'(strobes.vecOff);
        statusWrEn <= 1'b1;
        statusReg  <= entryStatus;
        linkWrEn   <= strobes.doLink;
        linkMode   <= strobes.tgtMode;
        linkData   <= curPc + ADDR_W'(strobes.linkOff);
        savedWrEn  <= strobes.doLink;
        savedMode  <= strobes.tgtMode;
        savedData  <= curStatus;
      end else if (strobes.ret) begin
        pcLoad     <= 1'b1;
        pcNext     <= retAddr;
        statusWrEn <= 1'b1;
        statusReg  <= retStatus;
      end
    end
  end

  // R6 and R7: handler always starts in primary state with IRQ masked
  a_r6_entry_primary: assert property (@(posedge clk) disable iff (!rstN)
    linkWrEn |-> (!statusReg.tBit && !statusReg.jBit && statusReg.iMask));

  // R5: link and saved-status writes travel together into one mode
  a_r5_link_save_pair: assert property (@(posedge clk) disable iff (!rstN)
    linkWrEn |-> (savedWrEn && pcLoad && statusWrEn && linkMode == savedMode));

  // R12: a link write always stems from the request sampled one edge earlier
  a_r12_link_origin: assert property (@(posedge clk) disable iff (!rstN)
    linkWrEn |-> $past(excReq));

  // R2: vector fetches stay word aligned
  a_r2_vec_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && linkWrEn) |-> (pcNext[1:0] == 2'b00));

  // R8: an accepted return loads the supplied address and writes no link
  a_r8_return_pc: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.ret) |-> (pcLoad && statusWrEn && !linkWrEn && pcNext == $past(retAddr)));

  // R9: a return from user mode raises nothing
  a_r9_user_return: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(retStrobe) && !$past(excReq) && $past(curStatus.mode) == MODE_USR)
      |-> (!pcLoad && !statusWrEn));

endmodule

// File: rtl/exc_ctrl_top.sv
module exc_ctrl_top
  import exc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                excReq,
  input  logic [2:0]          excKind,
  input  logic                abtExternal,
  input  logic [ADDR_W-1:0]   curPc,
  input  logic [STATUS_W-1:0] curStatus,
  input  logic [1:0]          isaState,
  input  logic [2:0]          routeCtl,
  input  logic                retStrobe,
  input  logic [ADDR_W-1:0]   retAddr,
  output logic                pcLoad,
  output logic [ADDR_W-1:0]   pcNext,
  output logic                linkWrEn,
  output logic [MODE_W-1:0]   linkMode,
  output logic [ADDR_W-1:0]   linkData,
  output logic                savedWrEn,
  output logic [MODE_W-1:0]   savedMode,
  output logic [STATUS_W-1:0] savedData,
  output logic                statusWrEn,
  output logic [STATUS_W-1:0] statusOut
);

  ctlStrobeT strobes;
  statusT    curStat;
  statusT    savedStat;
  statusT    newStat;

  assign curStat   = statusT'(curStatus);
  assign savedData = savedStat;
  assign statusOut = newStat;

  exc_ctl i_ctl (
    .excReq      (excReq),
    .excKind     (excKind),
    .abtExternal (abtExternal),
    .isaState    (isaState),
    .routeCtl    (routeCtl),
    .retStrobe   (retStrobe),
    .curMode     (curStat.mode),
    .strobes     (strobes)
  );

  exc_dp #(
    .ADDR_W   (ADDR_W),
    .VEC_BASE (VEC_BASE)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .excReq     (excReq),
    .retStrobe  (retStrobe),
    .curPc      (curPc),
    .curStatus  (curStat),
    .retAddr    (retAddr),
    .pcLoad     (pcLoad),
    .pcNext     (pcNext),
    .linkWrEn   (linkWrEn),
    .linkMode   (linkMode),
    .linkData   (linkData),
    .savedWrEn  (savedWrEn),
    .savedMode  (savedMode),
    .savedData  (savedStat),
    .statusWrEn (statusWrEn),
    .statusReg  (newStat)
  );

endmodule

// File: tb/test_exc_ctrl_top.sv
`timescale 1ns/1ps
module test_exc_ctrl_top;
  import exc_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excReq = 1'b0;
  logic [2:0]  excKind = '0;
  logic        abtExternal = 1'b0;
  logic [31:0] curPc = '0;
  logic [13:0] curStatus = '0;
  logic [1:0]  isaState = '0;
  logic [2:0]  routeCtl = '0;
  logic        retStrobe = 1'b0;
  logic [31:0] retAddr = '0;
  logic        pcLoad, linkWrEn, savedWrEn, statusWrEn;
  logic [31:0] pcNext, linkData;
  logic [4:0]  linkMode, savedMode;
  logic [13:0] savedData, statusOut;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exc_ctrl_top i_exc_ctrl_top (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excKind(excKind),
    .abtExternal(abtExternal), .curPc(curPc), .curStatus(curStatus),
    .isaState(isaState), .routeCtl(routeCtl), .retStrobe(retStrobe),
    .retAddr(retAddr), .pcLoad(pcLoad), .pcNext(pcNext), .linkWrEn(linkWrEn),
    .linkMode(linkMode), .linkData(linkData), .savedWrEn(savedWrEn),
    .savedMode(savedMode), .savedData(savedData), .statusWrEn(statusWrEn),
    .statusOut(statusOut)
  );

  typedef struct packed {
    logic [2:0] kind;
    logic [1:0] isa;
    logic [2:0] route;
    logic       ext;
    logic [4:0] mode;
    logic [7:0] vec;
    logic [3:0] off;
  } vecT;

  localparam int NV = 12;
  localparam vecT TBL [NV] = '{
    '{3'd1, 2'd0, 3'b000, 1'b0, MODE_UND, 8'h04, 4'd4},
    '{3'd1, 2'd1, 3'b000, 1'b0, MODE_UND, 8'h04, 4'd2},
    '{3'd2, 2'd1, 3'b000, 1'b0, MODE_SUP, 8'h08, 4'd2},
    '{3'd2, 2'd2, 3'b000, 1'b0, MODE_SUP, 8'h08, 4'd4},
    '{3'd3, 2'd0, 3'b100, 1'b0, MODE_ABT, 8'h0C, 4'd4},
    '{3'd3, 2'd1, 3'b100, 1'b1, MODE_MON, 8'h0C, 4'd4},
    '{3'd4, 2'd1, 3'b000, 1'b1, MODE_ABT, 8'h10, 4'd8},
    '{3'd4, 2'd0, 3'b100, 1'b1, MODE_MON, 8'h10, 4'd8},
    '{3'd5, 2'd1, 3'b010, 1'b0, MODE_MON, 8'h18, 4'd4},
    '{3'd5, 2'd2, 3'b101, 1'b0, MODE_IRQ, 8'h18, 4'd4},
    '{3'd6, 2'd0, 3'b001, 1'b0, MODE_MON, 8'h1C, 4'd4},
    '{3'd6, 2'd1, 3'b110, 1'b0, MODE_FIQ, 8'h1C, 4'd4}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Entry status by the mask and state rules (R6, R7)
  function automatic logic [13:0] expEntry(logic [13:0] cur, logic [2:0] kind,
                                           logic [4:0] mode);
    logic [13:0] r;
    r = cur;
    r[4:0] = mode;
    r[5] = 1'b0;
    r[9] = 1'b0;
    r[7] = 1'b1;
    if (kind == 3'd0 || kind == 3'd3 || kind == 3'd4 || kind == 3'd5) r[8] = 1'b1;
    if (kind == 3'd0 || kind == 3'd6) r[6] = 1'b1;
    return r;
  endfunction

  task automatic clearIn();
    excReq = 1'b0;
    retStrobe = 1'b0;
  endtask

  // Drive at a falling edge; outputs are sampled one full cycle later
  task automatic step();
    @(negedge clk);
  endtask

  task automatic finishUp();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
      finishUp();
    end
  end

  initial begin
    logic [13:0] st;
    logic [13:0] fiqSaved;
    logic [13:0] supSaved;

    // R1: state held during reset
    step();
    step();
    check("R1 pcLoad", 32'(pcLoad), 32'd1);
    check("R1 pcNext", pcNext, 32'h0);
    check("R1 status", 32'(statusOut), 32'h1D3);
    check("R1 statusWrEn", 32'(statusWrEn), 32'd1);
    check("R1 no link/saved", 32'({linkWrEn, savedWrEn}), 32'd0);
    rstN = 1'b1;
    step();
    // R12: idle after reset release
    check("R12 idle strobes", 32'({pcLoad, statusWrEn, linkWrEn, savedWrEn}), 32'd0);

    // R2..R7 through the vector table
    for (int i = 0; i < NV; i++) begin
      st = {4'(i), 1'(TBL[i].isa == 2'd2), 1'(i % 3 == 0), 1'b0, 1'(i % 2),
            1'(TBL[i].isa == 2'd1), MODE_USR};
      excReq = 1'b1;
      excKind = TBL[i].kind;
      isaState = TBL[i].isa;
      routeCtl = TBL[i].route;
      abtExternal = TBL[i].ext;
      curPc = 32'h1000 + 32'(i * 16);
      curStatus = st;
      step();
      clearIn();
      check("R2 vector", pcNext, 32'(TBL[i].vec));
      check("R2 pcLoad", 32'(pcLoad), 32'd1);
      check("R3 link data", linkData, 32'h1000 + 32'(i * 16) + 32'(TBL[i].off));
      check("R4 link mode", 32'(linkMode), 32'(TBL[i].mode));
      check("R5 saved data", 32'(savedData), 32'(st));
      check("R5 saved mode", 32'(savedMode), 32'(TBL[i].mode));
      check("R5 strobes", 32'({linkWrEn, savedWrEn, statusWrEn}), 32'b111);
      check("R6 R7 status", 32'(statusOut), 32'(expEntry(st, TBL[i].kind, TBL[i].mode)));
      step();
      check("R12 pulse ends", 32'({pcLoad, linkWrEn, savedWrEn, statusWrEn}), 32'd0);
    end

    // R8: FIQ entry then return restores everything from FIQ's slot
    fiqSaved = {4'hA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, MODE_USR};
    excReq = 1'b1; excKind = 3'd6; routeCtl = 3'b000; isaState = 2'd1;
    curPc = 32'h2000; curStatus = fiqSaved;
    step();
    clearIn();
    check("R4 fiq mode", 32'(statusOut[4:0]), 32'(MODE_FIQ));

    // R10: request and return together; request wins (supervisor call)
    supSaved = {4'h5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, MODE_FIQ};
    excReq = 1'b1; excKind = 3'd2; isaState = 2'd0; curPc = 32'h3000;
    curStatus = supSaved; retStrobe = 1'b1; retAddr = 32'hDEAD_0000;
    step();
    clearIn();
    check("R10 vector", pcNext, 32'h8);
    check("R10 link", 32'(linkWrEn), 32'd1);
    check("R10 link data", linkData, 32'h3004);

    retStrobe = 1'b1; retAddr = 32'h0000_2002;
    curStatus = {4'h0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, MODE_FIQ};
    step();
    clearIn();
    check("R8 return pc", pcNext, 32'h2002);
    check("R8 restored status", 32'(statusOut), 32'(fiqSaved));
    check("R8 strobes", 32'({pcLoad, statusWrEn, linkWrEn, savedWrEn}), 32'b1100);

    // R8: supervisor slot holds its own value
    retStrobe = 1'b1; retAddr = 32'h0000_3004;
    curStatus = {4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, MODE_SUP};
    step();
    clearIn();
    check("R8 sup slot", 32'(statusOut), 32'(supSaved));
    check("R8 sup pc", pcNext, 32'h3004);

    // R9: return from user mode is ignored
    retStrobe = 1'b1; retAddr = 32'h0000_7777;
    curStatus = {4'h3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, MODE_USR};
    step();
    clearIn();
    check("R9 no strobes", 32'({pcLoad, statusWrEn, linkWrEn, savedWrEn}), 32'd0);
    check("R9 pc kept", pcNext, 32'h3004);

    // R11: reset request kind 0
    st = {4'h9, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, MODE_IRQ};
    excReq = 1'b1; excKind = 3'd0; curStatus = st; curPc = 32'h4000;
    step();
    clearIn();
    check("R11 vector", pcNext, 32'h0);
    check("R11 status", 32'(statusOut), 32'(expEntry(st, 3'd0, MODE_SUP)));
    check("R11 no link/saved", 32'({pcLoad, statusWrEn, linkWrEn, savedWrEn}), 32'b1100);

    // R2: kind 7 is not accepted
    excReq = 1'b1; excKind = 3'd7;
    step();
    clearIn();
    check("R2 kind7 ignored", 32'({pcLoad, statusWrEn, linkWrEn, savedWrEn}), 32'd0);

    // R1: reset asserted mid-run
    rstN = 1'b0;
    step();
    check("R1 mid-run status", 32'(statusOut), 32'h1D3);
    check("R1 mid-run pc", {31'd0, pcLoad} + pcNext, 32'd1);
    rstN = 1'b1;
    step();

    finishUp();
  end

endmodule